// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block is the looping part of a small processor's program sequencer. It runs two kinds of hardware loop. A DO loop repeats a block of instructions. A REP repeat runs a single instruction several times. The block holds a 13-bit down-counter, a register with the address of the loop's last word, a loop-active flag with a saved copy for nesting, and a two-entry stack of loop-top addresses. Each cycle it looks at the fetch PC. It then either lets the sequencer take the incremented PC, or asserts `redirect` with the address to jump to. Taking the branch back to the loop top costs no extra cycles.

A REP is handled by a small state machine with two states. `S_IDLE` is the normal state. `S_REP` means the repeated instruction is being re-executed, and in this state fetch is stalled. The machine moves `S_IDLE`→`S_REP` when a REP starts with a non-zero count. It moves `S_REP`→`S_IDLE` once the counter has dropped to one or less. Otherwise it stays in its current state (`S_IDLE`→`S_IDLE`, `S_REP`→`S_REP`). While in `S_REP`, new DO or REP starts and loop-end detection are ignored.

Software reaches the counter through a 16-bit register port. Saving and restoring the loop-end register and the counter across nesting levels is left to software.

Top module: `hwloop_ctrl`

## Requirements
- R1: A DO start with a non-zero count loads the counter with the count and the loop-end register with the last-word address. It sets the loop flag, copies the previous loop flag into the nest bit, and pushes the loop-top address. All of these are visible from the next cycle.
- R2: Suppose the loop flag is set, fetch is valid, the fetch PC equals the loop-end register and the counter is not one. In that same cycle `redirect` is 1 and `redirect_pc` is the stack top, with no stall. The counter drops by one on the next edge.
- R3: At the loop-end fetch with the counter equal to one, `redirect` stays 0 so fetch continues at loop-end plus one. On the next edge the loop flag takes the nest bit's value and the stack is popped.
- R4: With the loop flag clear, a fetch PC equal to the loop-end register causes no redirect.
- R5: A REP with count N>0 stalls fetch for exactly N-1 cycles, starting the cycle after the start. The counter reads N, N-1, …, down to 1 over those cycles, and then stays at 1 with the stall released.
- R6: A DO start with count zero redirects in its own cycle to loop-end plus one. No push happens and the loop flag is unchanged.
- R7: A REP start with count zero redirects in its own cycle to the fetch PC plus two, and no stall follows.
- R8: A counter read returns its 13 bits zero-extended to 16. A write keeps only bits 12:0 of the written word.
- R9: A software write lands even when a loop-end decrement falls in the same cycle. The branch back to the loop top is still taken in that cycle.
- R10: The stack holds two entries. A push onto a full stack is dropped, keeping the old top, and sets a sticky overflow flag.
- R11: A pop from an empty stack leaves the depth at zero and sets a sticky underflow flag.
- R12: Synchronous active-high reset clears the counter, loop flag, nest bit, stack depth and both sticky flags.
- R13: When a nested inner loop exits, the loop flag stays set (restored from the nest bit) and the depth drops by one. The next loop-end redirect goes to the outer loop's top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch PC is meaningful this cycle |
| fetch_pc | input | 16 | Address being fetched |
| do_start | input | 1 | Start a DO loop this cycle |
| rep_start | input | 1 | Start a REP repeat this cycle |
| start_count | input | 13 | Iteration or repeat count for the start |
| do_top_addr | input | 16 | Address of the loop's first word |
| do_end_addr | input | 16 | Address of the loop's last word |
| lc_wr | input | 1 | Software write strobe for the counter |
| lc_wdata | input | 16 | Software write data |
| lc_rdata | output | 16 | Counter, zero-extended |
| redirect | output | 1 | Take `redirect_pc` instead of the incremented PC |
| redirect_pc | output | 16 | Branch target when `redirect` is 1 |
| fetch_stall | output | 1 | Hold fetch while a REP repeats |
| loop_flag | output | 1 | A DO loop is active |
| nest_bit | output | 1 | Saved loop flag of the enclosing level |
| stk_depth | output | 2 | Number of stack entries in use |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |

## Verification
Two counter updates can fall in the same cycle: a software write and the decrement caused by a loop-end fetch. The bench sets this up by pulsing `lc_wr` in the very cycle the fetch PC matches the loop-end address with a counter of three. It expects the branch to the loop top in that cycle, and the written value rather than two on the counter in the next cycle. A second collision occurs during overflow: a push onto a full stack is checked by forcing another loop-end branch, which must still return to the older top.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    localparam int CNT_W  = 13;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 16;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_REP  = 1'b1
    } rep_state_e;
endpackage

// File: rtl/hwloop_counter.sv
module hwloop_counter #(
    parameter int CW = 13,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_data,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic          dec_en,
    output logic [CW-1:0] cnt,
    output logic [BW-1:0] rd_data,
    output logic          is_one,
    output logic          is_zero
);
    logic [CW-1:0] cnt_q;
    logic          unused_hi;

    assign unused_hi = ^wr_data[BW-1:CW];

    // priority: software write, then start load, then decrement
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= wr_data[CW-1:0];
        else if (load_en)
            cnt_q <= load_val;
        else if (dec_en)
            cnt_q <= cnt_q - CW'(1);
    end

    assign cnt     = cnt_q;
    assign rd_data = {{(BW-CW){1'b0}}, cnt_q};
    assign is_one  = (cnt_q == CW'(1));
    assign is_zero = (cnt_q == '0);

    assert_sw_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wr_data[CW-1:0])));

    assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !wr_en && !load_en) |=> (cnt == CW'($past(cnt) - CW'(1))));
endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
    parameter int AW    = 16,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] top,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic          ovf,
    output logic          unf
);
    localparam int PW = $clog2(DEPTH+1);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] ptr_q;
    logic          ovf_q, unf_q;
    logic          full, empty, do_push, do_pop;

    assign full    = (ptr_q == PW'(DEPTH));
    assign empty   = (ptr_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty && !push;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (do_push && (ptr_q == PW'(g)))
                mem[g] <= push_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (do_push)
                ptr_q <= ptr_q + PW'(1);
            else if (do_pop)
                ptr_q <= ptr_q - PW'(1);
            if (push && full)
                ovf_q <= 1'b1;
            if (pop && !push && empty)
                unf_q <= 1'b1;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (ptr_q == PW'(i + 1))
                top = mem[i];
    end

    assign depth = ptr_q;
    assign ovf   = ovf_q;
    assign unf   = unf_q;

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    assert_push_full_R10: assert property (@(posedge clk) disable iff (rst)
        (push && depth == PW'(DEPTH)) |=> (ovf && $stable(depth)));

    assert_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && depth == '0) |=> (unf && depth == '0));
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int CW        = CNT_W,
    parameter int BW        = BUS_W,
    parameter int STK_DEPTH = 2,
    localparam int PW       = $clog2(STK_DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic          do_start,
    input  logic          rep_start,
    input  logic [CW-1:0] start_count,
    input  logic [AW-1:0] do_top_addr,
    input  logic [AW-1:0] do_end_addr,
    input  logic          lc_wr,
    input  logic [BW-1:0] lc_wdata,
    output logic [BW-1:0] lc_rdata,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc,
    output logic          fetch_stall,
    output logic          loop_flag,
    output logic          nest_bit,
    output logic [PW-1:0] stk_depth,
    output logic          stk_ovf,
    output logic          stk_unf
);
    rep_state_e    state_q, state_nx;
    logic [AW-1:0] la_q;
    logic          lf_q, nl_q;

    logic [CW-1:0] lc_val;
    logic          lc_one, lc_zero, lc_le1;
    logic [AW-1:0] stk_top;
    logic          cnt_zero;
    logic          do_go, rep_go, end_hit;
    logic          lc_load, lc_dec, stk_push, stk_pop;

    assign cnt_zero = (start_count == '0);
    assign lc_le1   = lc_one || lc_zero;

    hwloop_counter #(.CW(CW), .BW(BW)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (lc_wr),
        .wr_data  (lc_wdata),
        .load_en  (lc_load),
        .load_val (start_count),
        .dec_en   (lc_dec),
        .cnt      (lc_val),
        .rd_data  (lc_rdata),
        .is_one   (lc_one),
        .is_zero  (lc_zero)
    );

    hwloop_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (stk_push),
        .push_addr (do_top_addr),
        .pop       (stk_pop),
        .top       (stk_top),
        .depth     (stk_depth),
        .ovf       (stk_ovf),
        .unf       (stk_unf)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= S_IDLE;
        else
            state_q <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx    = state_q;
        do_go       = 1'b0;
        rep_go      = 1'b0;
        end_hit     = 1'b0;
        lc_dec      = 1'b0;
        fetch_stall = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                do_go   = do_start;
                rep_go  = rep_start && !do_start;
                end_hit = lf_q && fetch_valid && (fetch_pc == la_q)
                          && !do_start && !rep_start;
                lc_dec  = end_hit && !lc_one;
                if (rep_go && !cnt_zero)
                    state_nx = S_REP;
            end
            S_REP: begin
                fetch_stall = !lc_le1;
                lc_dec      = !lc_le1;
                if (lc_le1)
                    state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign lc_load  = do_go || rep_go;
    assign stk_push = do_go && !cnt_zero;
    assign stk_pop  = end_hit && lc_one;

    always_comb begin
        redirect    = 1'b0;
        redirect_pc = '0;
        if (do_go && cnt_zero) begin
            redirect    = 1'b1;
            redirect_pc = do_end_addr + AW'(1);
        end else if (rep_go && cnt_zero) begin
            redirect    = 1'b1;
            redirect_pc = fetch_pc + AW'(2);
        end else if (end_hit && !lc_one) begin
            redirect    = 1'b1;
            redirect_pc = stk_top;
        end
    end

    // loop-end address, loop flag and nest bit
    always_ff @(posedge clk) begin
        if (rst) begin
            la_q <= '0;
            lf_q <= 1'b0;
            nl_q <= 1'b0;
        end else if (stk_push) begin
            la_q <= do_end_addr;
            lf_q <= 1'b1;
            nl_q <= lf_q;
        end else if (stk_pop) begin
            lf_q <= nl_q;
        end
    end

    assign loop_flag = lf_q;
    assign nest_bit  = nl_q;

    assert_redirect_needs_lf_R4: assert property (@(posedge clk) disable iff (rst)
        (redirect && !do_start && !rep_start) |-> loop_flag);

    assert_exit_restore_R3: assert property (@(posedge clk) disable iff (rst)
        (end_hit && lc_one) |=> (loop_flag == $past(nest_bit)));

    assert_rep_counts_down_R5: assert property (@(posedge clk) disable iff (rst)
        (fetch_stall && !lc_wr) |=> (lc_val == CW'($past(lc_val) - CW'(1))));

    assert_zero_do_no_push_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && do_start && cnt_zero) |=> $stable(stk_depth));

    assert_no_stall_in_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE) |-> !fetch_stall);
endmodule

// File: tb/test_hwloop_ctrl.sv
`timescale 1ns/100ps
module test_hwloop_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b1;
    logic [15:0] fetch_pc = '0;
    logic        do_start = 1'b0, rep_start = 1'b0;
    logic [12:0] start_count = '0;
    logic [15:0] do_top_addr = '0, do_end_addr = '0;
    logic        lc_wr = 1'b0;
    logic [15:0] lc_wdata = '0;
    logic [15:0] lc_rdata, redirect_pc;
    logic        redirect, fetch_stall, loop_flag, nest_bit, stk_ovf, stk_unf;
    logic [1:0]  stk_depth;

    always #2.5 clk = ~clk;

    hwloop_ctrl i_hwloop_ctrl (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .do_start(do_start), .rep_start(rep_start), .start_count(start_count),
        .do_top_addr(do_top_addr), .do_end_addr(do_end_addr),
        .lc_wr(lc_wr), .lc_wdata(lc_wdata), .lc_rdata(lc_rdata),
        .redirect(redirect), .redirect_pc(redirect_pc), .fetch_stall(fetch_stall),
        .loop_flag(loop_flag), .nest_bit(nest_bit), .stk_depth(stk_depth),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    localparam int SIG_RDIR = 0, SIG_RPC = 1, SIG_STALL = 2, SIG_LC = 3,
                   SIG_LF = 4, SIG_NL = 5, SIG_DEPTH = 6, SIG_OVF = 7, SIG_UNF = 8;

    typedef struct {
        int          sig;
        logic [15:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    function automatic logic [15:0] observe(int sig);
        case (sig)
            SIG_RDIR:  return {15'd0, redirect};
            SIG_RPC:   return redirect_pc;
            SIG_STALL: return {15'd0, fetch_stall};
            SIG_LC:    return lc_rdata;
            SIG_LF:    return {15'd0, loop_flag};
            SIG_NL:    return {15'd0, nest_bit};
            SIG_DEPTH: return {14'd0, stk_depth};
            SIG_OVF:   return {15'd0, stk_ovf};
            default:   return {15'd0, stk_unf};
        endcase
    endfunction

    // driver side: queue an expectation for the current cycle
    task automatic expect_v(int sig, logic [15:0] v, string req);
        q.push_back('{sig, v, req});
    endtask

    // start a new cycle: inputs change on the falling edge
    task automatic cyc();
        @(negedge clk);
        do_start  = 1'b0;
        rep_start = 1'b0;
        lc_wr     = 1'b0;
    endtask

    // monitor: compare queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic [15:0] act;
                e = q.pop_front();
                act = observe(e.sig);
                checks++;
                if (act !== e.val) begin
                    errors++;
                    $display("FAIL %s sig%0d actual=%h expected=%h", e.req, e.sig, act, e.val);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        // R12: reset state
        fetch_pc = 16'h0010;
        expect_v(SIG_LC, 0, "R12"); expect_v(SIG_LF, 0, "R12"); expect_v(SIG_NL, 0, "R12");
        expect_v(SIG_DEPTH, 0, "R12"); expect_v(SIG_OVF, 0, "R12"); expect_v(SIG_UNF, 0, "R12");
        expect_v(SIG_RDIR, 0, "R12"); expect_v(SIG_STALL, 0, "R12");

        // R1/R2/R3: simple DO of 3 over 0x20..0x22
        cyc(); fetch_pc = 16'h001F; do_start = 1; start_count = 3;
        do_top_addr = 16'h0020; do_end_addr = 16'h0022;
        expect_v(SIG_RDIR, 0, "R1");
        cyc(); fetch_pc = 16'h0020;
        expect_v(SIG_LC, 3, "R1"); expect_v(SIG_LF, 1, "R1");
        expect_v(SIG_NL, 0, "R1"); expect_v(SIG_DEPTH, 1, "R1");
        cyc(); fetch_pc = 16'h0021; expect_v(SIG_RDIR, 0, "R2");
        cyc(); fetch_pc = 16'h0022;
        expect_v(SIG_RDIR, 1, "R2"); expect_v(SIG_RPC, 16'h0020, "R2"); expect_v(SIG_STALL, 0, "R2");
        cyc(); fetch_pc = 16'h0020; expect_v(SIG_LC, 2, "R2");
        cyc(); fetch_pc = 16'h0021;
        cyc(); fetch_pc = 16'h0022; expect_v(SIG_RDIR, 1, "R2");
        cyc(); fetch_pc = 16'h0020; expect_v(SIG_LC, 1, "R2");
        cyc(); fetch_pc = 16'h0021;
        cyc(); fetch_pc = 16'h0022; expect_v(SIG_RDIR, 0, "R3");
        cyc(); fetch_pc = 16'h0023;
        expect_v(SIG_LF, 0, "R3"); expect_v(SIG_DEPTH, 0, "R3"); expect_v(SIG_LC, 1, "R3");
        // R4: matching PC with the loop flag clear
        cyc(); fetch_pc = 16'h0022; expect_v(SIG_RDIR, 0, "R4");

        // R8: register access width
        cyc(); fetch_pc = 16'h0030; lc_wr = 1; lc_wdata = 16'hFFFF;
        cyc(); expect_v(SIG_LC, 16'h1FFF, "R8"); lc_wr = 1; lc_wdata = 16'hA005;
        cyc(); expect_v(SIG_LC, 16'h0005, "R8");

        // R9: software write collides with loop-end decrement
        cyc(); fetch_pc = 16'h003F; do_start = 1; start_count = 3;
        do_top_addr = 16'h0040; do_end_addr = 16'h0041;
        cyc(); fetch_pc = 16'h0040; expect_v(SIG_LC, 3, "R9");
        cyc(); fetch_pc = 16'h0041; lc_wr = 1; lc_wdata = 16'h0009;
        expect_v(SIG_RDIR, 1, "R9"); expect_v(SIG_RPC, 16'h0040, "R9");
        cyc(); fetch_pc = 16'h0040; expect_v(SIG_LC, 9, "R9");
        lc_wr = 1; lc_wdata = 16'h0001;
        cyc(); fetch_pc = 16'h0041; expect_v(SIG_LC, 1, "R9"); expect_v(SIG_RDIR, 0, "R3");
        cyc(); fetch_pc = 16'h0042; expect_v(SIG_LF, 0, "R3"); expect_v(SIG_DEPTH, 0, "R3");

        // R5: REP of 4
        cyc(); fetch_pc = 16'h0050; rep_start = 1; start_count = 4;
        expect_v(SIG_STALL, 0, "R5");
        cyc(); fetch_pc = 16'h0051; expect_v(SIG_LC, 4, "R5"); expect_v(SIG_STALL, 1, "R5");
        cyc(); expect_v(SIG_LC, 3, "R5"); expect_v(SIG_STALL, 1, "R5");
        cyc(); expect_v(SIG_LC, 2, "R5"); expect_v(SIG_STALL, 1, "R5");
        cyc(); expect_v(SIG_LC, 1, "R5"); expect_v(SIG_STALL, 0, "R5");
        cyc(); fetch_pc = 16'h0052; expect_v(SIG_LC, 1, "R5"); expect_v(SIG_STALL, 0, "R5");

        // R7: REP of zero
        cyc(); fetch_pc = 16'h0060; rep_start = 1; start_count = 0;
        expect_v(SIG_RDIR, 1, "R7"); expect_v(SIG_RPC, 16'h0062, "R7"); expect_v(SIG_STALL, 0, "R7");
        cyc(); fetch_pc = 16'h0062; expect_v(SIG_STALL, 0, "R7"); expect_v(SIG_LC, 0, "R7");

        // R6: DO of zero
        cyc(); fetch_pc = 16'h0070; do_start = 1; start_count = 0;
        do_top_addr = 16'h0071; do_end_addr = 16'h0075;
        expect_v(SIG_RDIR, 1, "R6"); expect_v(SIG_RPC, 16'h0076, "R6");
        cyc(); fetch_pc = 16'h0076;
        expect_v(SIG_LF, 0, "R6"); expect_v(SIG_DEPTH, 0, "R6"); expect_v(SIG_RDIR, 0, "R6");

        // R13: nested loops
        cyc(); fetch_pc = 16'h007F; do_start = 1; start_count = 2;
        do_top_addr = 16'h0080; do_end_addr = 16'h0088;
        cyc(); fetch_pc = 16'h0080;
        expect_v(SIG_LF, 1, "R13"); expect_v(SIG_NL, 0, "R13"); expect_v(SIG_DEPTH, 1, "R13");
        cyc(); fetch_pc = 16'h0081; do_start = 1; start_count = 2;
        do_top_addr = 16'h0082; do_end_addr = 16'h0084;
        cyc(); fetch_pc = 16'h0082;
        expect_v(SIG_NL, 1, "R13"); expect_v(SIG_DEPTH, 2, "R13"); expect_v(SIG_LC, 2, "R13");
        cyc(); fetch_pc = 16'h0084; expect_v(SIG_RDIR, 1, "R13"); expect_v(SIG_RPC, 16'h0082, "R13");
        cyc(); fetch_pc = 16'h0082; expect_v(SIG_LC, 1, "R13");
        cyc(); fetch_pc = 16'h0084; expect_v(SIG_RDIR, 0, "R13");
        cyc(); fetch_pc = 16'h0085; expect_v(SIG_LF, 1, "R13"); expect_v(SIG_DEPTH, 1, "R13");
        lc_wr = 1; lc_wdata = 16'h0002;
        cyc(); fetch_pc = 16'h0084; expect_v(SIG_RDIR, 1, "R13"); expect_v(SIG_RPC, 16'h0080, "R13");

        // R10/R11: overflow then underflow
        cyc(); fetch_pc = 16'h0080; do_start = 1; start_count = 1;
        do_top_addr = 16'h0090; do_end_addr = 16'h0091;
        cyc(); fetch_pc = 16'h0090; do_start = 1; start_count = 1;
        do_top_addr = 16'h00A0; do_end_addr = 16'h00A1;
        expect_v(SIG_DEPTH, 2, "R10"); expect_v(SIG_OVF, 0, "R10");
        cyc(); fetch_pc = 16'h00A0; expect_v(SIG_OVF, 1, "R10"); expect_v(SIG_DEPTH, 2, "R10");
        lc_wr = 1; lc_wdata = 16'h0002;
        cyc(); fetch_pc = 16'h00A1; expect_v(SIG_RDIR, 1, "R10"); expect_v(SIG_RPC, 16'h0090, "R10");
        cyc(); fetch_pc = 16'h00A1; expect_v(SIG_RDIR, 0, "R11");
        cyc(); fetch_pc = 16'h00A1; expect_v(SIG_DEPTH, 1, "R11"); expect_v(SIG_LF, 1, "R11");
        cyc(); fetch_pc = 16'h00A1; expect_v(SIG_DEPTH, 0, "R11"); expect_v(SIG_UNF, 0, "R11");
        cyc(); fetch_pc = 16'h00A2;
        expect_v(SIG_UNF, 1, "R11"); expect_v(SIG_DEPTH, 0, "R11"); expect_v(SIG_OVF, 1, "R10");

        // R12: reset clears sticky state
        cyc(); rst = 1'b1;
        cyc(); rst = 1'b0;
        expect_v(SIG_OVF, 0, "R12"); expect_v(SIG_UNF, 0, "R12"); expect_v(SIG_LF, 0, "R12");
        expect_v(SIG_NL, 0, "R12"); expect_v(SIG_DEPTH, 0, "R12"); expect_v(SIG_LC, 0, "R12");

        cyc(); cyc();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule